// File: doc/BRIEF.md
# Entropy Stream Online Health Monitor

This block sits beside a raw random-bit source and keeps checking that the source still behaves like noise. It takes one raw bit per cycle in which a valid strobe is high. It also takes the 32-bit words that a downstream assembler builds from those bits, each with its own strobe. Three checks run side by side on that traffic:

- a ones count over fixed windows of raw bits;
- a tracker for runs of identical bits, with a short and a long threshold;
- a comparator that flags two equal assembled words in a row.

Each check drives its own one-cycle failure pulse. The pulses are meant to set the sticky status flags of a generator's register block.

The monitor is on only while `enable` is high. Lowering `enable` clears every counter and every stored value. The run tracker and the word comparator each have a two-state machine:

- Run tracker: `SEQ_FRESH` means no bit has been seen yet and `SEQ_TRACK` means one has. The transition "first bit" goes from `SEQ_FRESH` to `SEQ_TRACK` on the first valid bit while enabled. The transition "disable" returns to `SEQ_FRESH` when `enable` is low.
- Word comparator: `CMP_EMPTY` means no word is stored and `CMP_ARMED` means one is. The transition "first word" goes from `CMP_EMPTY` to `CMP_ARMED` on the first word strobe while enabled. The transition "disable" returns to `CMP_EMPTY`.

Top module: `entropy_health_monitor`

## Requirements
- R1: After a synchronous reset, all four failure outputs are 0.
- R2: Every WINDOW_BITS valid bits form one window. On the edge that samples the last bit of a window, the monitor evaluates the window. `mono_fail` pulses when the window's count of ones is not strictly between ONES_LO and ONES_HI. The count and the window position then restart from zero.
- R3: A window holding exactly ONES_LO or ONES_HI ones fails. A window holding ONES_LO+1 or ONES_HI-1 ones passes.
- R4: `long_run_fail` pulses once, on the edge that samples the bit bringing a run of identical valid bits to RUN_SHORT.
- R5: `noise_fail` pulses once, on the edge that samples the bit bringing a run to RUN_LONG. A longer run gives no further pulse on either output.
- R6: A valid bit that differs from the previous valid bit restarts the run length at 1. The first valid bit after reset or after enable rises also starts a run of 1.
- R7: `stuck_fail` pulses on the edge that samples a word strobe whose word equals the previous strobed word. Three equal words in a row give two pulses.
- R8: The first strobed word after reset, or after enable rises, is stored but never compared.
- R9: While `enable` is low, no failure output pulses, and the window, run and word state is cleared.
- R10: Each failure output is registered. It is high for exactly the one cycle after the triggering edge. Cycles with the strobe low do not advance the window or the runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Monitor enable; low clears all state |
| bit_valid | input | 1 | Raw bit strobe |
| bit_in | input | 1 | Raw random bit |
| word_valid | input | 1 | Assembled word strobe |
| word_in | input | WORD_W | Assembled output word |
| mono_fail | output | 1 | Ones-count window failure pulse |
| long_run_fail | output | 1 | Run reached RUN_SHORT pulse |
| noise_fail | output | 1 | Run reached RUN_LONG pulse |
| stuck_fail | output | 1 | Repeated word pulse |

## Verification
The bench builds the monitor with a 64-bit window, a pass band of 24 to 40 exclusive, and run thresholds of 6 and 9. With these values, every window boundary count, both run thresholds and runs past the long threshold fit into a few hundred cycles. The word width stays at 32. The default 20,000-bit window and the 34 and 48 thresholds are the same logic with wider counters, and the bench does not run them.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
    typedef enum logic {
        SEQ_FRESH,
        SEQ_TRACK
    } seq_state_e;

    typedef enum logic {
        CMP_EMPTY,
        CMP_ARMED
    } cmp_state_e;
endpackage

// File: rtl/ehm_ones_window.sv
module ehm_ones_window #(
    parameter int WINDOW_BITS = 20000,
    parameter int ONES_LO     = 9654,
    parameter int ONES_HI     = 10346
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic bit_valid,
    input  logic bit_in,
    output logic fail_pulse
);
    localparam int IDX_W = (WINDOW_BITS > 1) ? $clog2(WINDOW_BITS) : 1;
    localparam int CNT_W = $clog2(WINDOW_BITS + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WINDOW_BITS - 1);
    localparam logic [CNT_W-1:0] BAND_LO  = CNT_W'(ONES_LO);
    localparam logic [CNT_W-1:0] BAND_HI  = CNT_W'(ONES_HI);

    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] ones_q;
    logic [CNT_W-1:0] ones_sum;
    logic             at_last;
    logic             in_band;
    logic             fail_q;

    always_comb begin
        ones_sum = ones_q + CNT_W'(bit_in);
        at_last  = (idx_q == IDX_LAST);
        in_band  = (ones_sum > BAND_LO) && (ones_sum < BAND_HI);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            idx_q  <= '0;
            ones_q <= '0;
            fail_q <= 1'b0;
        end else begin
            fail_q <= 1'b0;
            if (bit_valid) begin
                if (at_last) begin
                    idx_q  <= '0;
                    ones_q <= '0;
                    fail_q <= !in_band;
                end else begin
                    idx_q  <= idx_q + 1'b1;
                    ones_q <= ones_sum;
                end
            end
        end
    end

    assign fail_pulse = fail_q;

    // R2: a verdict only follows an enabled, valid bit
    a_r2_verdict_on_bit: assert property (@(posedge clk) disable iff (rst)
        fail_q |-> $past(bit_valid && enable));

    // R10: window verdict is a single-cycle pulse
    a_r10_mono_single: assert property (@(posedge clk) disable iff (rst)
        fail_q |=> !fail_q);
endmodule

// File: rtl/ehm_run_tracker.sv
module ehm_run_tracker
    import ehm_pkg::*;
#(
    parameter int RUN_SHORT = 34,
    parameter int RUN_LONG  = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic bit_valid,
    input  logic bit_in,
    output logic short_pulse,
    output logic long_pulse
);
    localparam int LEN_W = $clog2(RUN_LONG + 1);
    localparam logic [LEN_W-1:0] LEN_SAT    = LEN_W'(RUN_LONG);
    localparam logic [LEN_W-1:0] SHORT_PREV = LEN_W'(RUN_SHORT - 1);
    localparam logic [LEN_W-1:0] LONG_PREV  = LEN_W'(RUN_LONG - 1);

    seq_state_e       state_q, state_d;
    logic             prev_q;
    logic [LEN_W-1:0] len_q;
    logic             short_q;
    logic             long_q;
    logic             same_bit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_FRESH: if (enable && bit_valid) state_d = SEQ_TRACK;
            SEQ_TRACK: if (!enable) state_d = SEQ_FRESH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_FRESH;
        else     state_q <= state_d;
    end

    assign same_bit = (state_q == SEQ_TRACK) && (bit_in == prev_q);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            prev_q  <= 1'b0;
            len_q   <= '0;
            short_q <= 1'b0;
            long_q  <= 1'b0;
        end else begin
            short_q <= 1'b0;
            long_q  <= 1'b0;
            if (bit_valid) begin
                prev_q <= bit_in;
                if (same_bit) begin
                    if (len_q != LEN_SAT) len_q <= len_q + 1'b1;
                    short_q <= (len_q == SHORT_PREV);
                    long_q  <= (len_q == LONG_PREV);
                end else begin
                    len_q <= LEN_W'(1);
                end
            end
        end
    end

    assign short_pulse = short_q;
    assign long_pulse  = long_q;

    // R6: a changed bit restarts the run, so neither threshold fires next
    a_r6_change_restarts: assert property (@(posedge clk) disable iff (rst)
        (enable && bit_valid && state_q == SEQ_TRACK && bit_in != prev_q)
        |=> (len_q == LEN_W'(1)) && !short_q && !long_q);

    // R4: short threshold fires once per run
    a_r4_short_once: assert property (@(posedge clk) disable iff (rst)
        short_q |=> !short_q);

    // R5: the long threshold never coincides with the short one
    a_r5_long_apart: assert property (@(posedge clk) disable iff (rst)
        long_q |-> !short_q);
endmodule

// File: rtl/ehm_word_repeat.sv
module ehm_word_repeat
    import ehm_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic              stuck_pulse
);
    cmp_state_e        state_q, state_d;
    logic [WORD_W-1:0] prev_q;
    logic              stuck_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_EMPTY: if (enable && word_valid) state_d = CMP_ARMED;
            CMP_ARMED: if (!enable) state_d = CMP_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CMP_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            prev_q  <= '0;
            stuck_q <= 1'b0;
        end else begin
            stuck_q <= word_valid && (state_q == CMP_ARMED) && (word_in == prev_q);
            if (word_valid) prev_q <= word_in;
        end
    end

    assign stuck_pulse = stuck_q;

    // R8: nothing to compare against while empty
    a_r8_first_word_skip: assert property (@(posedge clk) disable iff (rst)
        (state_q == CMP_EMPTY) |=> !stuck_q);

    // R7: a repeat pulse only follows a word strobe
    a_r7_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        stuck_q |-> $past(word_valid));
endmodule

// File: rtl/entropy_health_monitor.sv
module entropy_health_monitor #(
    parameter int WINDOW_BITS = 20000,
    parameter int ONES_LO     = 9654,
    parameter int ONES_HI     = 10346,
    parameter int RUN_SHORT   = 34,
    parameter int RUN_LONG    = 48,
    parameter int WORD_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic              mono_fail,
    output logic              long_run_fail,
    output logic              noise_fail,
    output logic              stuck_fail
);
    ehm_ones_window #(
        .WINDOW_BITS(WINDOW_BITS),
        .ONES_LO    (ONES_LO),
        .ONES_HI    (ONES_HI)
    ) u_window (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .fail_pulse(mono_fail)
    );

    ehm_run_tracker #(
        .RUN_SHORT(RUN_SHORT),
        .RUN_LONG (RUN_LONG)
    ) u_runs (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .short_pulse(long_run_fail),
        .long_pulse (noise_fail)
    );

    ehm_word_repeat #(
        .WORD_W(WORD_W)
    ) u_words (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .word_valid (word_valid),
        .word_in    (word_in),
        .stuck_pulse(stuck_fail)
    );

    // R9: a disabled monitor stays quiet
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !(mono_fail || long_run_fail || noise_fail || stuck_fail));

    // R1: outputs clear in the cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> !(mono_fail || long_run_fail || noise_fail || stuck_fail));
endmodule

// File: tb/entropy_health_monitor_test.sv
module entropy_health_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int WIN   = 64;
    localparam int LO    = 24;
    localparam int HI    = 40;
    localparam int SHORT = 6;
    localparam int LONG  = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_in = '0;
    logic        mono_fail, long_run_fail, noise_fail, stuck_fail;

    int compared = 0;
    int mismatched = 0;
    string phase = "init";
    logic [3:0] expq[$];

    // reference model state
    int m_idx = 0, m_ones = 0, m_len = 0;
    bit m_prev = 0, m_have_bit = 0, m_have_word = 0;
    logic [31:0] m_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    entropy_health_monitor #(
        .WINDOW_BITS(WIN), .ONES_LO(LO), .ONES_HI(HI),
        .RUN_SHORT(SHORT), .RUN_LONG(LONG), .WORD_W(32)
    ) uut (
        .clk(clk), .rst(rst), .enable(enable),
        .bit_valid(bit_valid), .bit_in(bit_in),
        .word_valid(word_valid), .word_in(word_in),
        .mono_fail(mono_fail), .long_run_fail(long_run_fail),
        .noise_fail(noise_fail), .stuck_fail(stuck_fail)
    );

    // driver: drives one cycle and pushes the expected outputs for it
    task automatic step(input bit en, input bit bv, input bit b,
                        input bit wv, input logic [31:0] w);
        logic [3:0] exp_v;
        int total;
        @(negedge clk);
        enable = en; bit_valid = bv; bit_in = b; word_valid = wv; word_in = w;
        exp_v = 4'b0;
        if (!en) begin                                   // R9
            m_idx = 0; m_ones = 0; m_len = 0; m_prev = 0;
            m_have_bit = 0; m_have_word = 0; m_word = '0;
        end else begin
            if (bv) begin
                total = m_ones + int'(b);
                if (m_idx == WIN - 1) begin              // R2, R3
                    exp_v[0] = !(total > LO && total < HI);
                    m_idx = 0; m_ones = 0;
                end else begin
                    m_idx++; m_ones = total;
                end
                if (m_have_bit && b == m_prev) begin     // R4, R5
                    if (m_len < LONG) begin
                        m_len++;
                        if (m_len == SHORT) exp_v[1] = 1'b1;
                        if (m_len == LONG)  exp_v[2] = 1'b1;
                    end
                end else begin
                    m_len = 1;                           // R6
                end
                m_prev = b; m_have_bit = 1;
            end
            if (wv) begin                                // R7, R8
                if (m_have_word && w == m_word) exp_v[3] = 1'b1;
                m_word = w; m_have_word = 1;
            end
        end
        expq.push_back(exp_v);
    endtask

    task automatic send_bit(input bit b);
        step(1, 1, b, 0, '0);
    endtask

    task automatic send_run(input bit b, input int n);
        for (int i = 0; i < n; i++) send_bit(b);
    endtask

    task automatic send_word(input logic [31:0] w);
        step(1, 0, 0, 1, w);
    endtask

    // one full window holding exactly k ones
    task automatic send_window(input int k);
        for (int i = 0; i < WIN; i++) begin
            bit b;
            if (k <= WIN/2) b = (i < 2*k) ? (i % 2 == 0) : 1'b0;
            else            b = (i < 2*(WIN-k)) ? (i % 2 == 1) : 1'b1;
            send_bit(b);
        end
    endtask

    function automatic string req_of(input int idx);
        case (idx)
            0: return "R2/R3 mono_fail";
            1: return "R4 long_run_fail";
            2: return "R5 noise_fail";
            default: return "R7 stuck_fail";
        endcase
    endfunction

    // monitor: pops one expectation per driven cycle, after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (expq.size() > 0) begin
                logic [3:0] e, a;
                e = expq.pop_front();
                a = {stuck_fail, noise_fail, long_run_fail, mono_fail};
                compared++;
                if (a !== e) begin
                    mismatched++;
                    for (int k = 0; k < 4; k++)
                        if (a[k] !== e[k])
                            $display("FAIL [%s] %s: actual %0b expected %0b (R10 timing)",
                                     phase, req_of(k), a[k], e[k]);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        compared++;
        if ({stuck_fail, noise_fail, long_run_fail, mono_fail} !== 4'b0) begin
            mismatched++;
            $display("FAIL [reset] R1: actual %b expected 0000",
                     {stuck_fail, noise_fail, long_run_fail, mono_fail});
        end
        @(negedge clk);
        rst = 1'b0;

        // R2/R3: window boundaries, each window started fresh
        phase = "R3 low edge fail";   step(0,0,0,0,'0); send_window(LO);
        phase = "R3 low edge pass";   step(0,0,0,0,'0); send_window(LO + 1);
        phase = "R2 balanced pass";   step(0,0,0,0,'0); send_window(WIN/2);
        phase = "R3 high edge pass";  step(0,0,0,0,'0); send_window(HI - 1);
        phase = "R3 high edge fail";  step(0,0,0,0,'0); send_window(HI);
        phase = "R2 back to back";    send_window(LO); send_window(WIN/2);

        // R4/R5/R6: run thresholds
        phase = "R6 restart";         step(0,0,0,0,'0);
        send_run(1, SHORT - 1); send_run(0, SHORT - 1); send_run(1, 1);
        phase = "R4 short exact";     send_run(0, SHORT); send_bit(1);
        phase = "R5 long exact";      send_run(0, LONG); send_bit(1);
        phase = "R5 long beyond";     send_run(1, 3 * LONG); send_bit(0);

        // R10: strobe gaps do not break or advance a run
        phase = "R10 gaps";
        for (int i = 0; i < SHORT; i++) begin
            send_bit(1);
            step(1, 0, 0, 0, '0);
            step(1, 0, 1, 0, '0);
        end
        send_bit(0);

        // R7/R8: repeated words
        phase = "R8 first word";      step(0,0,0,0,'0); send_word(32'hA5A5_0001);
        phase = "R7 repeat";          send_word(32'hA5A5_0001);
        send_word(32'h1234_5678); send_word(32'hA5A5_0001);
        phase = "R7 triple";          send_word(32'hCAFE_0000); send_word(32'hCAFE_0000);
        send_word(32'hCAFE_0000);
        step(1, 0, 0, 0, '0);
        phase = "R7 gap repeat";      send_word(32'hCAFE_0000);
        phase = "R8 after enable";    step(0,0,0,0,'0); send_word(32'hCAFE_0000);
        send_word(32'hCAFE_0000);

        // R9: disabled traffic produces nothing and clears state
        phase = "R9 disabled";
        send_run(1, SHORT - 2);
        for (int i = 0; i < 2 * LONG; i++) step(0, 1, 1, 1, 32'h0);
        send_run(1, 2);
        send_word(32'h0);
        phase = "R9 mid-window clear";
        send_window(WIN/2);
        step(0,0,0,0,'0);
        send_window(LO);

        phase = "drain";
        step(1, 0, 0, 0, '0);
        repeat (3) @(posedge clk);
        #2;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule